// File: doc/BRIEF.md
# Serial Receive Channel with Per-Character Status Queue

This block is the receive half of one asynchronous serial channel. A free-running enable at sixteen times the bit rate paces it while it watches the serial input line. Each frame runs least significant bit first. It has a start bit, a parameterised number of data bits, an optional extra bit and one stop bit. The extra bit is a parity bit, or an address/data marker in multidrop operation. The block checks every finished character and places it in a queue of eight entries. Each queued character carries its own break, framing and parity flags.

A host reads the oldest character from a data port and pops it with a one-cycle read strobe. A status byte reports the following:
- whether data is waiting;
- whether the queue is full;
- a sticky overrun;
- the three error flags of the character at the head of the queue.

One more character may wait in the receive register behind a full queue. It enters the queue on the next read. A character that arrives while that slot is also taken replaces the waiting one and raises overrun. A one-cycle clear command resets the overrun.

Top module: `rx_char_queue`

## Requirements
- R1: Characters leave the queue in arrival order. `rx_data` shows the head character, or 0 when the queue is empty. `rx_status[1]` (full) is 1 while all eight entries are occupied.
- R2: A character that completes while the queue is full waits in the receive register. A read then moves it into the freed entry, so `rx_status[1]` stays 1 after that read, and the waiting character is returned last.
- R3: `rx_status[0]` (ready) is 1 while at least one character is queued. It falls only after a read that leaves the queue empty.
- R4: A character that completes while the queue is full and another character is already waiting sets `rx_status[4]` (overrun). The waiting character is discarded and the newest one waits in its place. Overrun stays 1 until a `clr_err` pulse; the overrun event wins over a clear in the same cycle.
- R5: `rx_status[6]` (framing) is 1 for a head character whose stop bit, sampled near its middle, was 0.
- R6: `par_mode` selects the extra bit:
  - 0: none; `rx_status[5]` is 0.
  - 1: parity, with `par_sel`=0 even and 1 odd; `rx_status[5]` is 1 on a parity mismatch.
  - 2: forced parity; the received bit must equal `par_sel`, and `rx_status[5]` is 1 when it differs.
  - 3: multidrop; `rx_status[5]` holds the received address/data bit.
- R7: `rx_status[7:5]` report the flags stored with the head character, so they change as the head advances. They are 0 while the queue is empty.
- R8: A low level on `rxd` that is no longer low at the eighth oversample of the start bit is a false start and produces no character.
- R9: A frame whose data bits, extra bit (if present) and stop bit are all 0 is a break. It is queued as one entry with data 0 and `rx_status[7]` set. No further character is started until `rxd` has returned high.
- R10: After reset `rx_status` and `rx_data` are 0.
- R11: A read strobe while the queue is empty changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| par_mode | input | 2 | Extra-bit mode (0 none, 1 parity, 2 forced, 3 multidrop) |
| par_sel | input | 1 | Odd-parity select, or the forced parity value |
| rd_strobe | input | 1 | Pops the head character |
| clr_err | input | 1 | Clears the sticky overrun |
| rx_data | output | DATA_BITS | Head character |
| rx_status | output | 8 | {break, framing, parity/AD, overrun, 0, 0, full, ready} |

## Verification
The embedded properties watch, on every cycle, the invariants that connect the queue, the waiting register and the status byte:
- the waiting register is only occupied while the queue is full;
- the queue is never pushed past its depth or popped while empty;
- overrun stays set until it is cleared and rises only when a character was already waiting;
- ready falls only after a read;
- a false start returns the receiver to idle.

Only the directed scenarios can show the character-level results: byte values, the arrival order, the discarded character after an overrun, the parity arithmetic in each mode, head flags advancing on reads and the single entry recorded for a long break.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    PM_NONE  = 2'd0,
    PM_PAR   = 2'd1,
    PM_FORCE = 2'd2,
    PM_MULTI = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_flags_t;

  // Flag stored in the parity position. data_xor is the XOR of all data bits.
  function automatic logic rxq_par_flag(input logic [1:0] mode, input logic sel,
                                        input logic data_xor, input logic xbit);
    logic f;
    case (mode)
      PM_PAR:   f = data_xor ^ xbit ^ sel;
      PM_FORCE: f = xbit ^ sel;
      PM_MULTI: f = xbit;
      default:  f = 1'b0;
    endcase
    return f;
  endfunction

  function automatic logic rxq_is_break(input logic data_zero, input logic has_x,
                                        input logic xbit, input logic stop_bit);
    return data_zero && !stop_bit && (!has_x || !xbit);
  endfunction

endpackage

// File: rtl/rxq_sampler.sv
module rxq_sampler
  import rxq_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic [1:0]           par_mode,
  input  logic                 par_sel,
  output logic                 frm_done,
  output logic [DATA_BITS-1:0] frm_data,
  output rx_flags_t            frm_flags
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] MID_CNT  = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] LAST_CNT = CW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP, RX_WAITHI
  } rx_state_e;

  rx_state_e            st;
  logic [1:0]           sync_q;
  logic                 rxd_s;
  logic [CW-1:0]        cnt;
  logic [BW-1:0]        bit_idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 xbit;
  logic                 has_x;
  logic                 false_start;
  logic                 bit_point;

  assign rxd_s       = sync_q[1];
  assign has_x       = (par_mode != PM_NONE);
  assign bit_point   = os_tick && (cnt == LAST_CNT);
  assign false_start = os_tick && (st == RX_START) && (cnt == MID_CNT) && rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      st        <= RX_IDLE;
      cnt       <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      xbit      <= 1'b0;
      frm_done  <= 1'b0;
      frm_data  <= '0;
      frm_flags <= '0;
    end else begin
      sync_q   <= {sync_q[0], rxd};
      frm_done <= 1'b0;
      if (os_tick) begin
        case (st)
          RX_IDLE: if (!rxd_s) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: if (cnt == MID_CNT) begin
            cnt     <= '0;
            bit_idx <= '0;
            xbit    <= 1'b0;
            st      <= rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_DATA: if (bit_point) begin
            cnt   <= '0;
            shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
            if (bit_idx == LAST_BIT) st <= has_x ? RX_EXTRA : RX_STOP;
            else                     bit_idx <= bit_idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_EXTRA: if (bit_point) begin
            cnt  <= '0;
            xbit <= rxd_s;
            st   <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_STOP: if (bit_point) begin
            cnt           <= '0;
            frm_done      <= 1'b1;
            frm_data      <= shreg;
            frm_flags.fe  <= !rxd_s;
            frm_flags.pe  <= rxq_par_flag(par_mode, par_sel, ^shreg, xbit);
            frm_flags.brk <= rxq_is_break(shreg == '0, has_x, xbit, rxd_s);
            st            <= rxd_s ? RX_IDLE : RX_WAITHI;
          end else begin
            cnt <= cnt + 1'b1;
          end
          RX_WAITHI: if (rxd_s) st <= RX_IDLE;
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  p_false_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (st == RX_IDLE && !frm_done));

  p_break_holds_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_flags.brk) |-> (st == RX_WAITHI || st == RX_IDLE));

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               wdata,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[i] <= '0;
      else if (push && wr_ptr == PW'(i))     mem[i] <= wdata;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (count < CW'(DEPTH)));

  p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 16,
  parameter int DEPTH     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic [1:0]           par_mode,
  input  logic                 par_sel,
  input  logic                 rd_strobe,
  input  logic                 clr_err,
  output logic [DATA_BITS-1:0] rx_data,
  output logic [7:0]           rx_status
);
  localparam int EW = DATA_BITS + 3;
  localparam int CW = $clog2(DEPTH + 1);

  logic                 frm_done;
  logic [DATA_BITS-1:0] frm_data;
  rx_flags_t            frm_flags;
  logic [EW-1:0]        frame_in;

  logic [EW-1:0] head;
  logic [CW-1:0] count;
  logic          fifo_full, fifo_nonempty;

  logic          hold_v;
  logic [EW-1:0] hold_q;
  logic          push, rd_pop, hold_load, hold_clear, ovr_evt;
  logic [EW-1:0] wdata;
  logic          ovr_q;
  rx_flags_t     head_flags;

  rxq_sampler #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_sampler (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_mode(par_mode), .par_sel(par_sel),
    .frm_done(frm_done), .frm_data(frm_data), .frm_flags(frm_flags)
  );

  assign frame_in = {frm_flags, frm_data};

  rxq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(rd_pop),
    .wdata(wdata), .rdata(head), .count(count)
  );

  assign fifo_full     = (count == CW'(DEPTH));
  assign fifo_nonempty = (count != '0);
  assign rd_pop        = rd_strobe && fifo_nonempty;

  always_comb begin
    push       = 1'b0;
    wdata      = frame_in;
    hold_load  = 1'b0;
    hold_clear = 1'b0;
    ovr_evt    = 1'b0;
    if (hold_v && rd_pop) begin
      push  = 1'b1;
      wdata = hold_q;
      if (frm_done) hold_load  = 1'b1;
      else          hold_clear = 1'b1;
    end else if (frm_done) begin
      if (!fifo_full || rd_pop) begin
        push = 1'b1;
      end else begin
        hold_load = 1'b1;
        ovr_evt   = hold_v;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (hold_load) begin
        hold_v <= 1'b1;
        hold_q <= frame_in;
      end else if (hold_clear) begin
        hold_v <= 1'b0;
      end
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (clr_err) ovr_q <= 1'b0;
    end
  end

  assign head_flags = fifo_nonempty ? rx_flags_t'(head[EW-1:DATA_BITS]) : '0;
  assign rx_data    = fifo_nonempty ? head[DATA_BITS-1:0] : '0;
  assign rx_status  = {head_flags.brk, head_flags.fe, head_flags.pe, ovr_q,
                       2'b00, fifo_full, fifo_nonempty};

  p_hold_needs_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> fifo_full);

  p_full_kept_on_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && rd_strobe) |=> rx_status[1]);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !clr_err) |=> ovr_q);

  p_ovr_needs_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(hold_v));

  p_rdy_falls_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_status[0]) |-> $past(rd_strobe));

endmodule

// File: tb/rx_char_queue_bench.sv
module rx_char_queue_bench;
  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] par_mode = 2'd0;
  logic       par_sel = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       clr_err = 1'b0;
  logic [7:0] rx_data;
  logic [7:0] rx_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  rx_char_queue u_rx_char_queue (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .par_mode(par_mode), .par_sel(par_sel), .rd_strobe(rd_strobe),
    .clr_err(clr_err), .rx_data(rx_data), .rx_status(rx_status)
  );

  always #4 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      os_tick = (div == 3);
      div = (div + 1) % 4;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit has_x, input logic xb,
                            input logic stopv);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (has_x) send_bit(xb);
    send_bit(stopv);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int n = 0;
    for (int i = 0; i < 8; i++) if (d[i]) n++;
    return (n % 2) == 1;
  endfunction

  task automatic t_reset();
    check("R10 status", rx_status, 0);
    check("R10 data", rx_data, 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 0, 0, 1);
    check("R3 ready set", rx_status, 8'h01);
    check("R1 data", rx_data, 8'hA5);
    do_read();
    check("R3 ready cleared", rx_status, 0);
    do_read();
    check("R11 empty read status", rx_status, 0);
    check("R11 empty read data", rx_data, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) send_frame(8'(8'h10 + i), 0, 0, 1);
    check("R1 full", rx_status, 8'h03);
    send_frame(8'h77, 0, 0, 1);
    check("R2 waiting no overrun", rx_status, 8'h03);
    check("R1 head first", rx_data, 8'h10);
    do_read();
    check("R2 full after refill", rx_status, 8'h03);
    for (int i = 1; i < 8; i++) begin
      check("R1 order", rx_data, 8'h10 + i);
      do_read();
      check("R3 ready while nonempty", int'(rx_status[0]), 1);
    end
    check("R2 waiting char last", rx_data, 8'h77);
    check("R2 full cleared", int'(rx_status[1]), 0);
    do_read();
    check("R3 empty", rx_status, 0);
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 8; i++) send_frame(8'(8'h20 + i), 0, 0, 1);
    send_frame(8'h99, 0, 0, 1);
    check("R4 no overrun yet", int'(rx_status[4]), 0);
    send_frame(8'hAA, 0, 0, 1);
    check("R4 overrun set", rx_status, 8'h13);
    for (int i = 0; i < 8; i++) do_read();
    check("R4 newest kept", rx_data, 8'hAA);
    do_read();
    check("R4 overrun sticky", rx_status, 8'h10);
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
    check("R4 overrun cleared", rx_status, 0);
  endtask

  task automatic t_framing();
    send_frame(8'h55, 0, 0, 0);
    check("R5 framing flag", rx_status, 8'h41);
    check("R5 data", rx_data, 8'h55);
    do_read();
  endtask

  task automatic t_parity();
    logic [7:0] d = 8'h37;
    logic p_even = ones_odd(d);
    par_mode = 2'd1; par_sel = 1'b0;
    send_frame(d, 1, p_even, 1);
    check("R6 even good", rx_status, 8'h01); do_read();
    send_frame(d, 1, !p_even, 1);
    check("R6 even bad", rx_status, 8'h21); do_read();
    par_sel = 1'b1;
    send_frame(d, 1, !p_even, 1);
    check("R6 odd good", rx_status, 8'h01); do_read();
    par_mode = 2'd2; par_sel = 1'b1;
    send_frame(8'h00, 1, 1'b1, 1);
    check("R6 force match", rx_status, 8'h01); do_read();
    send_frame(8'h01, 1, 1'b0, 1);
    check("R6 force mismatch", rx_status, 8'h21); do_read();
    par_mode = 2'd3; par_sel = 1'b0;
    send_frame(8'h42, 1, 1'b1, 1);
    check("R6 multidrop address", rx_status, 8'h21); do_read();
    send_frame(8'h42, 1, 1'b0, 1);
    check("R6 multidrop data", rx_status, 8'h01); do_read();
    par_mode = 2'd0;
  endtask

  task automatic t_head_flags();
    par_mode = 2'd1; par_sel = 1'b0;
    send_frame(8'h01, 1, 1'b0, 1);
    send_frame(8'h03, 1, 1'b0, 1);
    check("R7 head bad parity", rx_status, 8'h21);
    do_read();
    check("R7 next head clean", rx_status, 8'h01);
    check("R7 next head data", rx_data, 8'h03);
    do_read();
    par_mode = 2'd0;
  endtask

  task automatic t_false_start();
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK * 12) @(negedge clk);
    check("R8 false start ignored", rx_status, 0);
  endtask

  task automatic t_break();
    rxd = 1'b0;
    repeat (BITCLK * 30) @(negedge clk);
    check("R9 one entry during break", rx_status, 8'hC1);
    rxd = 1'b1;
    repeat (BITCLK * 2) @(negedge clk);
    check("R9 break data", rx_data, 0);
    do_read();
    check("R9 single entry", rx_status, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_fill();
    t_overrun();
    t_framing();
    t_parity();
    t_head_flags();
    t_false_start();
    t_break();
    finish_run();
  end
endmodule